// File: doc/BRIEF.md
# Clock source mode controller

This block is the digital control part of an on-chip clock generator. It keeps a small mode register that picks one of four operating modes. Three of them run the system clock, either from the frequency-locked-loop clock or from the internal reference clock. The fourth is stop, which produces no system clock at all. The mode register also drives the enable of the frequency-locked loop and the enable of the reference oscillator. The chosen clock passes through a power-of-two divider and leaves as the system clock. A status field reports which source is actually driving that clock.

Moving between the two sources is glitch-free. Each source has its own gate. A gate opens only after the other gate is seen closed through a two-stage synchronizer, and it opens or closes only while its own clock is low. A gate also closes only at a divider boundary, where every divider tap is low. A new divide ratio is taken up at the same kind of boundary. The block also holds a trim word for the reference oscillator and passes it on.

Top module: `ckgen_ctrl`

## Requirements
- R1: While reset is held, fll_en and ref_en are 1, src_status is 00, sys_clk is low and trim_out is 0. After reset the mode is FLL engaged, so sys_clk follows fll_clk and src_status becomes 01.
- R2: With mode_sel 00 (FLL engaged) and stop_req low, fll_en is 1 on the next ref_clk edge. sys_clk is then fll_clk divided by the ratio, and src_status reads 01. src_status never takes the code 11.
- R3: With mode_sel 01 (FLL bypassed) and stop_req low, fll_en stays 1. sys_clk is then ref_clk divided by the ratio, and src_status reads 10.
- R4: With mode_sel 10 (FLL bypassed, low power) and stop_req low, fll_en is 0 on the next ref_clk edge. sys_clk is then ref_clk divided by the ratio, and src_status reads 10.
- R5: With stop_req high, fll_en is 0, sys_clk makes no edges and src_status reads 00. ref_en then equals ref_keep_stop. Whenever stop_req is low, ref_en is 1.
- R6: mode_sel code 11 is ignored, and the previously selected mode stays in force.
- R7: div_sel codes 00, 01, 10 and 11 divide the selected clock by 1, 2, 4 and 8, with a high time of half the period.
- R8: The two source gates are never open together. No high or low phase of sys_clk is shorter than half an fll_clk period, across source switches, divider changes and stop.
- R9: trim_out takes trim_val on a ref_clk edge where trim_load is high, and holds its value otherwise.
- R10: stop_req takes precedence over mode_sel. With stop_req high, a mode_sel of 00 still gives fll_en 0 and no sys_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal reference clock; also clocks the mode register |
| fll_clk | input | 1 | Clock from the frequency-locked loop |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 FLL engaged, 01 FLL bypassed, 10 FLL bypassed low power, 11 ignored |
| stop_req | input | 1 | Enter stop mode while high |
| ref_keep_stop | input | 1 | Keep the reference oscillator enabled during stop |
| div_sel | input | DIV_SEL_W | Divider select, divide by 2 to the power of the code |
| trim_load | input | 1 | Load trim_val into the trim register |
| trim_val | input | TRIM_W | New trim word |
| sys_clk | output | 1 | Divided system clock |
| fll_en | output | 1 | Enable for the frequency-locked loop |
| ref_en | output | 1 | Enable for the reference oscillator |
| src_status | output | 2 | Active source: 00 none, 01 FLL, 10 reference |
| trim_out | output | TRIM_W | Trim word held for the reference oscillator |

## Verification
The assertions assume a few things about the environment. mode_sel, stop_req, ref_keep_stop and the trim inputs are synchronous to ref_clk. Both clocks run without pause, and ref_clk keeps toggling even while ref_en is low. div_sel changes only rarely compared with the divider period. The stimulus changes every control input at a falling edge of ref_clk, keeps both clocks free-running, and runs fll_clk at a reduced ratio to ref_clk; the block's logic does not depend on the ratio. It then waits long enough for each switchover and status synchronization to finish before it measures the period, the high time and the edge count of sys_clk.

// File: rtl/ckgen_pkg.sv
`timescale 1ns/1ps
package ckgen_pkg;
    localparam int NUM_SRC = 2;
    localparam int SRC_FLL = 0;
    localparam int SRC_REF = 1;

    typedef enum logic [1:0] {
        MODE_FEI   = 2'b00,
        MODE_FBI   = 2'b01,
        MODE_FBILP = 2'b10,
        MODE_STOP  = 2'b11
    } ck_mode_e;

    typedef enum logic [1:0] {
        STAT_NONE = 2'b00,
        STAT_FLL  = 2'b01,
        STAT_REF  = 2'b10
    } ck_stat_e;

    localparam logic [1:0] SEL_RESERVED = 2'b11;
endpackage

// File: rtl/ckgen_mode_ctrl.sv
`timescale 1ns/1ps
module ckgen_mode_ctrl
    import ckgen_pkg::*;
#(
    parameter int TRIM_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic               ref_clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_sel,
    input  logic               stop_req,
    input  logic               ref_keep_stop,
    input  logic               trim_load,
    input  logic [TRIM_W-1:0]  trim_val,
    input  logic [NUM_SRC-1:0] src_en,
    output logic [NUM_SRC-1:0] src_req,
    output logic               fll_en,
    output logic               ref_en,
    output logic [1:0]         src_status,
    output logic [TRIM_W-1:0]  trim_out
);
    typedef struct packed {
        ck_mode_e               mode;
        ck_mode_e               run_mode;
        logic                   fll_en;
        logic                   ref_en;
        logic [TRIM_W-1:0]      trim;
        logic [SYNC_STAGES-1:0] fll_sync;
        logic [SYNC_STAGES-1:0] ref_sync;
        ck_stat_e               status;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  fll_seen, ref_seen;

    always_comb begin
        ctrl_d = ctrl_q;
        // last valid run selection survives a reserved code and stop
        if (mode_sel != SEL_RESERVED) begin
            ctrl_d.run_mode = ck_mode_e'(mode_sel);
        end
        ctrl_d.mode   = stop_req ? MODE_STOP : ctrl_d.run_mode;
        ctrl_d.fll_en = (ctrl_d.mode == MODE_FEI) || (ctrl_d.mode == MODE_FBI);
        ctrl_d.ref_en = (ctrl_d.mode != MODE_STOP) || ref_keep_stop;
        if (trim_load) begin
            ctrl_d.trim = trim_val;
        end
        ctrl_d.fll_sync = {ctrl_q.fll_sync[SYNC_STAGES-2:0], src_en[SRC_FLL]};
        ctrl_d.ref_sync = {ctrl_q.ref_sync[SYNC_STAGES-2:0], src_en[SRC_REF]};
        fll_seen = ctrl_q.fll_sync[SYNC_STAGES-1];
        ref_seen = ctrl_q.ref_sync[SYNC_STAGES-1];
        if (fll_seen && !ref_seen) begin
            ctrl_d.status = STAT_FLL;
        end else if (ref_seen && !fll_seen) begin
            ctrl_d.status = STAT_REF;
        end else begin
            ctrl_d.status = STAT_NONE;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{mode: MODE_FEI, run_mode: MODE_FEI, fll_en: 1'b1,
                        ref_en: 1'b1, trim: '0, fll_sync: '0, ref_sync: '0,
                        status: STAT_NONE};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign src_req[SRC_FLL] = (ctrl_q.mode == MODE_FEI);
    assign src_req[SRC_REF] = (ctrl_q.mode == MODE_FBI) || (ctrl_q.mode == MODE_FBILP);
    assign fll_en     = ctrl_q.fll_en;
    assign ref_en     = ctrl_q.ref_en;
    assign src_status = ctrl_q.status;
    assign trim_out   = ctrl_q.trim;
endmodule

// File: rtl/ckgen_src_gate.sv
`timescale 1ns/1ps
module ckgen_src_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic req,
    input  logic peer_en,
    input  logic at_zero,
    output logic en
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] req_sync;
        logic [SYNC_STAGES-1:0] peer_sync;
        logic                   arm;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  en_d, en_q;

    always_comb begin
        gate_d           = gate_q;
        gate_d.req_sync  = {gate_q.req_sync[SYNC_STAGES-2:0], req};
        gate_d.peer_sync = {gate_q.peer_sync[SYNC_STAGES-2:0], peer_en};
        // arm only once the other gate is seen closed in this domain
        gate_d.arm       = gate_q.req_sync[SYNC_STAGES-1] && !gate_q.peer_sync[SYNC_STAGES-1];
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    // open at once when armed, close only where every divider tap is low
    always_comb begin
        en_d = en_q;
        if (gate_q.arm) begin
            en_d = 1'b1;
        end else if (at_zero) begin
            en_d = 1'b0;
        end
    end

    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en = en_q;
endmodule

// File: rtl/ckgen_divider.sv
`timescale 1ns/1ps
module ckgen_divider #(
    parameter int SEL_W = 2
) (
    input  logic             mux_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             sys_clk,
    output logic             at_zero
);
    localparam int NUM_DIV = 2 ** SEL_W;
    localparam int CNT_W   = NUM_DIV - 1;

    logic [CNT_W-1:0]   cnt_d, cnt_q;
    logic [SEL_W-1:0]   sel_d, sel_q;
    logic [NUM_DIV-1:0] taps;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge mux_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // ratio change only while the source is low and all taps are low
    always_comb begin
        sel_d = sel_q;
        if (cnt_q == '0) begin
            sel_d = div_sel;
        end
    end

    always_ff @(negedge mux_clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign taps[0] = mux_clk;
    for (genvar k = 1; k < NUM_DIV; k++) begin : g_tap
        assign taps[k] = cnt_q[k-1];
    end

    assign sys_clk = taps[sel_q];
    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/ckgen_ctrl.sv
`timescale 1ns/1ps
module ckgen_ctrl
    import ckgen_pkg::*;
#(
    parameter int TRIM_W      = 9,
    parameter int DIV_SEL_W   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 ref_clk,
    input  logic                 fll_clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_sel,
    input  logic                 stop_req,
    input  logic                 ref_keep_stop,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 trim_load,
    input  logic [TRIM_W-1:0]    trim_val,
    output logic                 sys_clk,
    output logic                 fll_en,
    output logic                 ref_en,
    output logic [1:0]           src_status,
    output logic [TRIM_W-1:0]    trim_out
);
    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] src_req;
    logic [NUM_SRC-1:0] src_en;
    logic               mux_clk;
    logic               div_zero;

    assign src_clk[SRC_FLL] = fll_clk;
    assign src_clk[SRC_REF] = ref_clk;

    ckgen_mode_ctrl #(
        .TRIM_W      (TRIM_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_mode (
        .ref_clk       (ref_clk),
        .rst_n         (rst_n),
        .mode_sel      (mode_sel),
        .stop_req      (stop_req),
        .ref_keep_stop (ref_keep_stop),
        .trim_load     (trim_load),
        .trim_val      (trim_val),
        .src_en        (src_en),
        .src_req       (src_req),
        .fll_en        (fll_en),
        .ref_en        (ref_en),
        .src_status    (src_status),
        .trim_out      (trim_out)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        ckgen_src_gate #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_gate (
            .src_clk (src_clk[g]),
            .rst_n   (rst_n),
            .req     (src_req[g]),
            .peer_en (src_en[NUM_SRC-1-g]),
            .at_zero (div_zero),
            .en      (src_en[g])
        );
    end

    assign mux_clk = |(src_clk & src_en);

    ckgen_divider #(
        .SEL_W (DIV_SEL_W)
    ) u_div (
        .mux_clk (mux_clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .sys_clk (sys_clk),
        .at_zero (div_zero)
    );
endmodule

// File: rtl/ckgen_ctrl_chk.sv
`timescale 1ns/1ps
module ckgen_ctrl_chk #(
    parameter int TRIM_W = 9
) (
    input logic              ref_clk,
    input logic              fll_clk,
    input logic              rst_n,
    input logic [1:0]        mode_sel,
    input logic              stop_req,
    input logic              ref_keep_stop,
    input logic              trim_load,
    input logic [TRIM_W-1:0] trim_val,
    input logic              sys_clk,
    input logic              fll_en,
    input logic              ref_en,
    input logic [1:0]        src_status,
    input logic [TRIM_W-1:0] trim_out,
    input logic [1:0]        src_en
);
    p_excl_src_r8: assert property (@(posedge fll_clk) disable iff (!rst_n)
        !(src_en[0] && src_en[1]));

    p_idle_low_r5: assert property (@(posedge fll_clk) disable iff (!rst_n)
        (src_en == 2'b00) |-> !sys_clk);

    p_stop_fll_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        stop_req |=> !fll_en);

    p_stop_ref_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (stop_req && !ref_keep_stop) |=> !ref_en);

    p_run_ref_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !stop_req |=> ref_en);

    p_lowpwr_fll_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!stop_req && mode_sel == 2'b10) |=> !fll_en);

    p_engaged_fll_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!stop_req && mode_sel == 2'b00) |=> fll_en);

    p_status_code_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        src_status != 2'b11);

    p_trim_hold_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !trim_load |=> $stable(trim_out));

    p_trim_load_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        trim_load |=> (trim_out == $past(trim_val)));
endmodule

bind ckgen_ctrl ckgen_ctrl_chk #(.TRIM_W(TRIM_W)) u_chk (
    .ref_clk       (ref_clk),
    .fll_clk       (fll_clk),
    .rst_n         (rst_n),
    .mode_sel      (mode_sel),
    .stop_req      (stop_req),
    .ref_keep_stop (ref_keep_stop),
    .trim_load     (trim_load),
    .trim_val      (trim_val),
    .sys_clk       (sys_clk),
    .fll_en        (fll_en),
    .ref_en        (ref_en),
    .src_status    (src_status),
    .trim_out      (trim_out),
    .src_en        (src_en)
);

// File: tb/ckgen_ctrl_tb_top.sv
`timescale 1ns/1ps
module ckgen_ctrl_tb_top;
    localparam real FLL_PER = 2.0;
    localparam int  RATIO   = 16;
    localparam real REF_PER = FLL_PER * RATIO;
    localparam real SETTLE  = 40.0 * REF_PER;
    localparam real WIN     = 32.0 * REF_PER;

    logic       ref_clk = 1'b0;
    logic       fll_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       stop_req = 1'b0;
    logic       ref_keep_stop = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       trim_load = 1'b0;
    logic [8:0] trim_val = '0;
    logic       sys_clk, fll_en, ref_en;
    logic [1:0] src_status;
    logic [8:0] trim_out;

    always #(FLL_PER / 2.0) fll_clk = ~fll_clk;
    always #(REF_PER / 2.0) ref_clk = ~ref_clk;

    ckgen_ctrl dut_i (
        .ref_clk(ref_clk), .fll_clk(fll_clk), .rst_n(rst_n),
        .mode_sel(mode_sel), .stop_req(stop_req), .ref_keep_stop(ref_keep_stop),
        .div_sel(div_sel), .trim_load(trim_load), .trim_val(trim_val),
        .sys_clk(sys_clk), .fll_en(fll_en), .ref_en(ref_en),
        .src_status(src_status), .trim_out(trim_out)
    );

    typedef struct {
        string      tag;
        logic       exp_fll;
        logic       exp_ref;
        logic [1:0] exp_stat;
        real        exp_per;
    } item_t;

    item_t sb_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    vec_done = 1'b0;
    bit    finished = 1'b0;

    // sys_clk edge tracking
    real t_rise = 0.0, t_rise_prev = 0.0, t_edge = 0.0, last_hi = 0.0;
    real min_phase = 1.0e9;
    int  n_rise = 0;
    bit  track = 1'b0, seen_edge = 1'b0;

    always @(posedge sys_clk) begin
        if (track && seen_edge && ($realtime - t_edge) < min_phase) min_phase = $realtime - t_edge;
        if (track) seen_edge = 1'b1;
        t_edge      = $realtime;
        t_rise_prev = t_rise;
        t_rise      = $realtime;
        n_rise++;
    end

    always @(negedge sys_clk) begin
        if (track && seen_edge && ($realtime - t_edge) < min_phase) min_phase = $realtime - t_edge;
        if (track) seen_edge = 1'b1;
        t_edge  = $realtime;
        last_hi = $realtime - t_rise;
    end

    task automatic chk_int(string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic chk_real(string what, real act, real exp);
        n_chk++;
        if ((act - exp) > 0.01 || (exp - act) > 0.01) begin
            n_bad++;
            $display("FAIL %s: got %0.3f expected %0.3f", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // driver: apply one setting and queue its expected result
    task automatic apply(string tag, logic [1:0] m, logic s, logic k, logic [1:0] d,
                         logic ef, logic er, logic [1:0] es, real ep);
        item_t it;
        @(negedge ref_clk);
        mode_sel = m; stop_req = s; ref_keep_stop = k; div_sel = d;
        it.tag = tag; it.exp_fll = ef; it.exp_ref = er; it.exp_stat = es; it.exp_per = ep;
        vec_done = 1'b0;
        sb_q.push_back(it);
        wait (vec_done);
    endtask

    // monitor: pop expected items and compare once the design has settled
    initial begin
        item_t it;
        int    n0;
        forever begin
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            #(SETTLE + 0.25);
            n0 = n_rise;
            #(WIN);
            chk_int({it.tag, " fll_en"}, int'(fll_en), int'(it.exp_fll));
            chk_int({it.tag, " ref_en"}, int'(ref_en), int'(it.exp_ref));
            chk_int({it.tag, " src_status"}, int'(src_status), int'(it.exp_stat));
            if (it.exp_per == 0.0) begin
                chk_int({it.tag, " sys_clk edges"}, n_rise - n0, 0);
            end else begin
                chk_real({it.tag, " period"}, t_rise - t_rise_prev, it.exp_per);
                chk_real({it.tag, " high time"}, last_hi, it.exp_per / 2.0);
            end
            vec_done = 1'b1;
        end
    end

    initial begin
        #(100000.0);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        #(3.0 * REF_PER + 0.25);
        // R1 reset state
        chk_int("R1 reset fll_en", int'(fll_en), 1);
        chk_int("R1 reset ref_en", int'(ref_en), 1);
        chk_int("R1 reset src_status", int'(src_status), 0);
        chk_int("R1 reset sys_clk", int'(sys_clk), 0);
        chk_int("R1 reset trim_out", int'(trim_out), 0);
        @(negedge ref_clk);
        rst_n = 1'b1;
        track = 1'b1;

        apply("R1 R2 engaged div1",      2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 2'b01, FLL_PER);
        apply("R7 engaged div2",         2'b00, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 2'b01, 2.0 * FLL_PER);
        apply("R7 engaged div8",         2'b00, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 2'b01, 8.0 * FLL_PER);
        apply("R3 bypassed div1",        2'b01, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 2'b10, REF_PER);
        apply("R3 R7 bypassed div4",     2'b01, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1, 2'b10, 4.0 * REF_PER);
        apply("R6 reserved after byp",   2'b11, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1, 2'b10, 4.0 * REF_PER);
        apply("R4 lowpower div2",        2'b10, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 2'b10, 2.0 * REF_PER);
        apply("R5 R10 stop keep ref",    2'b00, 1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 2'b00, 0.0);
        apply("R5 stop drop ref",        2'b00, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 2'b00, 0.0);
        apply("R2 R5 engaged from stop", 2'b00, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 2'b01, 8.0 * FLL_PER);
        apply("R4 R7 lowpower div8",     2'b10, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 2'b10, 8.0 * REF_PER);
        apply("R2 R7 engaged div4",      2'b00, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1, 2'b01, 4.0 * FLL_PER);
        apply("R6 reserved after eng",   2'b11, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1, 2'b01, 4.0 * FLL_PER);
        apply("R5 stop from engaged",    2'b11, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 0.0);
        apply("R6 reserved leaves stop", 2'b11, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 2'b01, FLL_PER);

        // R9 trim register load and hold
        @(negedge ref_clk);
        trim_val  = 9'h1A5;
        trim_load = 1'b1;
        @(negedge ref_clk);
        trim_load = 1'b0;
        trim_val  = 9'h05A;
        #0.25;
        chk_int("R9 trim loaded", int'(trim_out), 'h1A5);
        @(negedge ref_clk);
        @(negedge ref_clk);
        #0.25;
        chk_int("R9 trim held", int'(trim_out), 'h1A5);

        // R8 shortest sys_clk phase over the whole run
        chk_int("R8 no short phase", (min_phase >= FLL_PER / 2.0 - 0.01) ? 1 : 0, 1);
        finish_run();
    end
endmodule